// File: doc/BRIEF.md
# Hot-Plug Event Notifier

This block gathers the hot-plug status events of a single downstream slot and decides how software hears about them. Five sticky status bits record the events. Each bit is set by a one-cycle event pulse and stays set until software writes a one to clear it.

The block combines the pending bits with per-event enables and a slot-wide interrupt enable. From these it raises one of four indications:
- a one-cycle MSI request,
- a level-sensitive INTx line,
- a one-cycle power-management wake request, or
- a level-sensitive general-purpose event line used when the slot runs in legacy notification mode.

Message formatting and link transport belong to the surrounding logic. The block only raises the requests. A load strobe marks the window in which register defaults are being loaded. A command-completed pulse seen during that window is dropped.

Top module: `hpev_notify`

## Requirements
- R1: Status bit positions are 0 attention button, 1 power fault, 2 latch sensor changed, 3 presence changed, 4 command completed. A high bit on `evt_i` sets the matching `status_o` bit at the next rising edge, and the bit stays set with no further pulses.
- R2: A high bit on `clr_i` clears the matching status bit at the next rising edge. Clear bits for other positions leave a status bit unchanged. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: While `load_i` is high, a command-completed pulse does not set status bit 4. Pulses on the other four positions still set their bits.
- R4: An interrupt is pending only while at least one status bit is set with its `evt_en_i` bit set, `hp_ie_i` is high and `legacy_i` is low. Otherwise `msi_req_o` and `intx_o` stay low.
- R5: With `msi_en_i` high, a pending interrupt gives a single one-cycle `msi_req_o` pulse when the pending condition first becomes true. Further events while it stays pending give no new pulse, and `intx_o` stays low.
- R6: With `msi_en_i` low and `intx_dis_i` low, `intx_o` is high for as long as an interrupt is pending. With `intx_dis_i` high, `intx_o` stays low.
- R7: With `d3hot_i` high and `legacy_i` low, an enabled pending status bit other than command completed gives a one-cycle `wake_req_o` pulse whatever the value of `hp_ie_i`. With `hp_ie_i` also high, the interrupt is raised as well.
- R8: Command completed never causes `wake_req_o`, even in D3hot with its enable set.
- R9: With `legacy_i` high, `gpe_o` is high while any enabled status bit is set, including command completed. In that mode `msi_req_o`, `intx_o` and `wake_req_o` stay low.
- R10: All four notification outputs change at the second rising edge after the edge that samples the event pulse. In other words, they follow the registered status by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 5 | One-cycle event pulses, one per status bit |
| clr_i | input | 5 | Write-one-to-clear strobe per status bit |
| load_i | input | 1 | High while register defaults are being loaded |
| evt_en_i | input | 5 | Per-event notification enables |
| hp_ie_i | input | 1 | Slot-wide hot-plug interrupt enable |
| msi_en_i | input | 1 | Select MSI delivery |
| intx_dis_i | input | 1 | Disable INTx delivery |
| d3hot_i | input | 1 | Port is in the D3hot low-power state |
| legacy_i | input | 1 | Route events to the general-purpose event line |
| status_o | output | 5 | Sticky status bits |
| msi_req_o | output | 1 | One-cycle MSI request |
| intx_o | output | 1 | INTx level |
| wake_req_o | output | 1 | One-cycle wake message request |
| gpe_o | output | 1 | General-purpose event level |

## Verification
The bench targets the following cases, with what a faulty design would do in each:
- **Event and clear in the same cycle on one bit.** A design that lets the clear win loses the event.
- **Command-completed pulse during default loading.** A design that ignores the load window shows a spurious command-completed bit.
- **D3hot with the slot-wide enable clear.** A design that gates wake on that enable never wakes the host.
- **Command completed in D3hot.** A design that treats command completed like the other bits issues a wake.
- **A second event while an interrupt is already pending.** A level-triggered design emits a duplicate MSI.
- **Legacy mode with every enable set.** A design that ignores the legacy bit still raises MSI, INTx or wake.

// File: rtl/hpev_pkg.sv
package hpev_pkg;
    localparam int N_EVT     = 5;
    localparam int EV_ATTN   = 0;
    localparam int EV_PFAULT = 1;
    localparam int EV_LATCH  = 2;
    localparam int EV_PRES   = 3;
    localparam int EV_CMD    = 4;

    typedef logic [N_EVT-1:0] evec_t;

    // Bits allowed to raise a wake request: all but command completed.
    localparam evec_t WAKE_MASK = ~(evec_t'(1) << EV_CMD);

    typedef struct packed {
        evec_t sts;
    } bank_st_t;

    typedef struct packed {
        logic msi_prev;
        logic wake_prev;
        logic msi_req;
        logic wake_req;
        logic intx;
        logic gpe;
    } route_st_t;
endpackage

// File: rtl/hpev_status_bank.sv
module hpev_status_bank
    import hpev_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  evec_t evt_i,
    input  evec_t clr_i,
    input  logic  load_i,
    output evec_t status_o
);
    bank_st_t s_d, s_q;
    evec_t    set_v;
    evec_t    keep_v;

    for (genvar i = 0; i < N_EVT; i++) begin : g_bit
        if (i == EV_CMD) begin : g_cmd
            // Defaults loading must never flag a completed command.
            assign set_v[i] = evt_i[i] & ~load_i;
        end else begin : g_evt
            assign set_v[i] = evt_i[i];
        end
        assign keep_v[i] = s_q.sts[i] & ~clr_i[i];
    end

    always_comb begin
        s_d     = s_q;
        s_d.sts = set_v | keep_v;   // set has priority over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = s_q.sts;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & ~(evec_t'(load_i) << EV_CMD))) |=>
        ((s_q.sts & $past(evt_i & ~(evec_t'(load_i) << EV_CMD)))
          == $past(evt_i & ~(evec_t'(load_i) << EV_CMD)))); // R1

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~evt_i)) |=> ((s_q.sts & $past(clr_i & ~evt_i)) == '0)); // R2

    AST_LOAD_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !s_q.sts[EV_CMD]) |=> !s_q.sts[EV_CMD]); // R3
endmodule

// File: rtl/hpev_route.sv
module hpev_route
    import hpev_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  evec_t status_i,
    input  evec_t evt_en_i,
    input  logic  hp_ie_i,
    input  logic  msi_en_i,
    input  logic  intx_dis_i,
    input  logic  d3hot_i,
    input  logic  legacy_i,
    output logic  msi_req_o,
    output logic  intx_o,
    output logic  wake_req_o,
    output logic  gpe_o
);
    route_st_t r_d, r_q;
    evec_t     armed;
    logic      int_cond;
    logic      wake_cond;
    logic      msi_cond;

    always_comb begin
        armed     = status_i & evt_en_i;
        int_cond  = hp_ie_i & (|armed) & ~legacy_i;
        wake_cond = d3hot_i & (|(armed & WAKE_MASK)) & ~legacy_i;
        msi_cond  = int_cond & msi_en_i;

        r_d           = r_q;
        r_d.msi_prev  = msi_cond;
        r_d.msi_req   = msi_cond & ~r_q.msi_prev;
        r_d.wake_prev = wake_cond;
        r_d.wake_req  = wake_cond & ~r_q.wake_prev;
        r_d.intx      = int_cond & ~msi_en_i & ~intx_dis_i;
        r_d.gpe       = legacy_i & (|armed);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign msi_req_o  = r_q.msi_req;
    assign intx_o     = r_q.intx;
    assign wake_req_o = r_q.wake_req;
    assign gpe_o      = r_q.gpe;

    AST_NO_INT_WITHOUT_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        !hp_ie_i |=> (!msi_req_o && !intx_o)); // R4

    AST_MSI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req_o |=> !msi_req_o); // R5

    AST_INTX_NOT_WITH_MSI: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_en_i || intx_dis_i) |=> !intx_o); // R6

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |=> !wake_req_o); // R7

    AST_NO_CMD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_i & evt_en_i & WAKE_MASK) == '0) |=> !wake_req_o); // R8

    AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_i |=> (!msi_req_o && !intx_o && !wake_req_o)); // R9
endmodule

// File: rtl/hpev_notify.sv
module hpev_notify
    import hpev_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_i,
    input  logic [N_EVT-1:0] clr_i,
    input  logic             load_i,
    input  logic [N_EVT-1:0] evt_en_i,
    input  logic             hp_ie_i,
    input  logic             msi_en_i,
    input  logic             intx_dis_i,
    input  logic             d3hot_i,
    input  logic             legacy_i,
    output logic [N_EVT-1:0] status_o,
    output logic             msi_req_o,
    output logic             intx_o,
    output logic             wake_req_o,
    output logic             gpe_o
);
    evec_t sts_w;

    hpev_status_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (clr_i),
        .load_i   (load_i),
        .status_o (sts_w)
    );

    hpev_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_i   (sts_w),
        .evt_en_i   (evt_en_i),
        .hp_ie_i    (hp_ie_i),
        .msi_en_i   (msi_en_i),
        .intx_dis_i (intx_dis_i),
        .d3hot_i    (d3hot_i),
        .legacy_i   (legacy_i),
        .msi_req_o  (msi_req_o),
        .intx_o     (intx_o),
        .wake_req_o (wake_req_o),
        .gpe_o      (gpe_o)
    );

    assign status_o = sts_w;
endmodule

// File: tb/hpev_notify_tb_top.sv
module hpev_notify_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] evt = '0, clr = '0, en = '0;
    logic       load = 1'b0, hpie = 1'b0, msi = 1'b0, intxd = 1'b0, d3 = 1'b0, leg = 1'b0;
    logic [4:0] status;
    logic       msi_req, intx, wake_req, gpe;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpev_notify dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr), .load_i(load),
        .evt_en_i(en), .hp_ie_i(hpie), .msi_en_i(msi), .intx_dis_i(intxd),
        .d3hot_i(d3), .legacy_i(leg), .status_o(status), .msi_req_o(msi_req),
        .intx_o(intx), .wake_req_o(wake_req), .gpe_o(gpe)
    );

    // exp bits: {msi_req, intx, wake_req, gpe}
    typedef struct packed {
        logic [4:0] evt;
        logic [4:0] en;
        logic       hpie, msi, intxd, d3, leg;
        logic [3:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'b00001, 5'b11111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1000},
        '{5'b00001, 5'b11111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100},
        '{5'b00010, 5'b11111, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000},
        '{5'b00100, 5'b11111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0010},
        '{5'b01000, 5'b11111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1010},
        '{5'b10000, 5'b11111, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0100},
        '{5'b10000, 5'b11111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000},
        '{5'b00001, 5'b11110, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000},
        '{5'b00010, 5'b11111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0001},
        '{5'b01000, 5'b11111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
        '{5'b00100, 5'b11011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000},
        '{5'b10000, 5'b11111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0001}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_all();
        @(negedge clk) clr = 5'b11111;
        @(negedge clk) clr = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fire(input logic [4:0] e);
        @(negedge clk) evt = e;
        @(negedge clk) evt = '0;   // first edge has sampled the pulse
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] got;
        repeat (3) @(negedge clk);
        // Reset state
        chk(status == 5'b0, "R1 reset status", status, 0);
        chk({msi_req, intx, wake_req, gpe} == 4'b0, "R4 reset outputs",
            {msi_req, intx, wake_req, gpe}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            en = VECS[v].en; hpie = VECS[v].hpie; msi = VECS[v].msi;
            intxd = VECS[v].intxd; d3 = VECS[v].d3; leg = VECS[v].leg;
            fire(VECS[v].evt);
            @(negedge clk);
            got = {msi_req, intx, wake_req, gpe};
            chk(got == VECS[v].exp, $sformatf("R4 R5 R6 R7 R8 R9 vector %0d", v),
                got, VECS[v].exp);
            chk(status == VECS[v].evt, $sformatf("R1 vector %0d status", v),
                status, VECS[v].evt);
            clear_all();
        end

        // R10 latency and R6 level hold, INTx mode
        en = 5'b11111; hpie = 1'b1; msi = 1'b0; intxd = 1'b0; d3 = 1'b0; leg = 1'b0;
        @(negedge clk) evt = 5'b00001;
        @(negedge clk) evt = '0;
        chk(intx == 1'b0, "R10 intx not after first edge", intx, 0);
        chk(status == 5'b00001, "R1 status after first edge", status, 1);
        @(negedge clk);
        chk(intx == 1'b1, "R10 intx after second edge", intx, 1);
        repeat (4) @(negedge clk);
        chk(intx == 1'b1, "R6 intx held while pending", intx, 1);
        chk(status == 5'b00001, "R1 status sticky", status, 1);
        // clear of another bit leaves it
        @(negedge clk) clr = 5'b00010;
        @(negedge clk) clr = '0;
        chk(status == 5'b00001, "R2 other clear ignored", status, 1);
        // event and clear in the same cycle: set wins
        @(negedge clk) begin evt = 5'b00001; clr = 5'b00001; end
        @(negedge clk) begin evt = '0; clr = '0; end
        chk(status == 5'b00001, "R2 set wins over clear", status, 1);
        @(negedge clk) clr = 5'b00001;
        @(negedge clk) clr = '0;
        chk(status == 5'b00000, "R2 w1c clears", status, 0);
        @(negedge clk);
        chk(intx == 1'b0, "R6 intx drops after clear", intx, 0);
        clear_all();

        // R5 single MSI pulse, no repeat while pending
        msi = 1'b1;
        fire(5'b00001);
        @(negedge clk);
        chk(msi_req == 1'b1, "R5 msi pulse", msi_req, 1);
        @(negedge clk);
        chk(msi_req == 1'b0, "R5 msi one cycle", msi_req, 0);
        fire(5'b00010);
        @(negedge clk);
        chk(msi_req == 1'b0, "R5 no repeat while pending", msi_req, 0);
        chk(intx == 1'b0, "R5 no intx in msi mode", intx, 0);
        clear_all();

        // R8 then R7: command completed in D3 gives no wake; later AB does
        msi = 1'b0; d3 = 1'b1; hpie = 1'b0;
        fire(5'b10000);
        @(negedge clk);
        chk(wake_req == 1'b0, "R8 cmd done no wake", wake_req, 0);
        fire(5'b00001);
        @(negedge clk);
        chk(wake_req == 1'b1, "R7 wake after attention", wake_req, 1);
        @(negedge clk);
        chk(wake_req == 1'b0, "R7 wake one cycle", wake_req, 0);
        chk(intx == 1'b0, "R4 no intx with global off", intx, 0);
        clear_all();
        d3 = 1'b0;

        // R3 defaults loading blocks command completed only
        @(negedge clk) begin load = 1'b1; evt = 5'b10001; end
        @(negedge clk) begin load = 1'b0; evt = '0; end
        chk(status == 5'b00001, "R3 cmd blocked during load", status, 5'b00001);
        fire(5'b10000);
        chk(status == 5'b10001, "R3 cmd sets after load", status, 5'b10001);
        clear_all();

        // R9 legacy level held, drops on clear
        leg = 1'b1; hpie = 1'b1; msi = 1'b1;
        fire(5'b01000);
        repeat (3) @(negedge clk);
        chk(gpe == 1'b1, "R9 gpe level held", gpe, 1);
        chk({msi_req, intx, wake_req} == 3'b0, "R9 other outputs quiet",
            {msi_req, intx, wake_req}, 0);
        clear_all();
        chk(gpe == 1'b0, "R9 gpe drops after clear", gpe, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule